// File: doc/BRIEF.md
# Low-Power Event Counter with Register Control

This block is a 16-bit event counter run entirely through a small register port. Software picks a counting mode and an active-edge selection while the block is off, then switches it on. Switching it on does not start counting: a separate start bit, written once the block is already on, starts continuous counting. In simple mode the counter adds one on each selected edge of input A. In quadrature mode it counts up or down from the phase relation of inputs A and B.

The counter runs from 0 up to a ceiling (the reload value) and wraps at either end. The reload and compare registers load late, as they would across a slow clock boundary. A write to either one is taken only while the block is on. The new value appears a fixed number of cycles later, and in that same cycle a sticky "load done" flag rises. Each flag stays up until software writes a 1 to its bit in the clear register. A third sticky flag marks that the count has reached the compare value.

Top module: `lpcnt_top`

## Requirements
- R1: After reset, reading returns the following. Config (offset 0) reads 0. Control (offset 1) reads 0. Reload (offset 2) reads 0xFFFF. Compare (offset 3) reads 0. Status (offset 4) reads 0. Count (offset 6) reads 0. Offset 5 is the write-only clear register, and it and offset 7 read as 0.
- R2: A write to reload or compare made while the enable bit is 0 is dropped, and the register keeps its value.
- R3: A write to reload or compare accepted at clock edge k shows its new value after edge k+3. At that same edge, its done flag sets: status bit 0 for reload, bit 1 for compare.
- R4: Each status flag stays set until a write to offset 5 carries a 1 in the same bit position. If a flag is set and cleared in the same cycle, the set wins.
- R5: Control bit 0 is enable and bit 1 is start. Start takes effect only when it is written while enable is already 1, and counting happens only while both bits are 1.
- R6: Config holds quadrature mode in bit 0, edge select in bits 2:1 and prescaler code in bits 5:3. A write to config is dropped while the block is enabled, and it is also dropped when the edge select would be 11.
- R7: Edge select 00 means rising edges, 01 falling edges and 10 both edges. In simple mode (bit 0 = 0) each selected edge on in_a adds one, and in_b has no effect.
- R8: In quadrature mode, a selected edge on one input with the other input steady counts as follows. A rising edge counts up when B is low. A rising edge on B counts up when A is high. A falling edge on A counts up when B is high. A falling edge on B counts up when A is low. Every other case counts down.
- R9: Counting up from a value at or above reload gives 0. Counting down from 0 gives the reload value.
- R10: Writing control with bit 0 = 0 clears enable, start and the count, and drops any reload or compare load still pending.
- R11: Status bit 2 sets when a count step makes the count equal to the compare value.
- R12: In quadrature mode, a cycle in which both inputs change does not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 3 | Register offset for read and write |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| in_a | input | 1 | Counting input A, synchronous to clk |
| in_b | input | 1 | Counting input B, synchronous to clk |

## Verification
The embedded properties assume three things. The inputs in_a and in_b are already synchronous to clk. The bus carries at most one write per cycle. The load delay is at least one cycle. The stimulus changes the inputs and the bus only on the falling clock edge, and it issues single-cycle writes. It moves quadrature inputs one phase at a time, except for one deliberate step where both inputs change together, used to check that no count occurs. A behavioural model in the bench tracks every register and flag, and the read data for the current offset is compared against it on every clock.

// File: rtl/lpcnt_pkg.sv
// Shared types and register offsets for the low-power event counter.
package lpcnt_pkg;

    // Active-edge selection; 2'b11 is not a legal setting.
    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_BAD  = 2'b11
    } edge_sel_e;

    // Config register layout, bit 0 upward: quad, edge_sel[2:1], presc[5:3].
    typedef struct packed {
        logic [2:0] presc;
        edge_sel_e  edge_sel;
        logic       quad;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    localparam logic [2:0] A_CFG    = 3'd0;
    localparam logic [2:0] A_CTRL   = 3'd1;
    localparam logic [2:0] A_RELOAD = 3'd2;
    localparam logic [2:0] A_CMP    = 3'd3;
    localparam logic [2:0] A_STAT   = 3'd4;
    localparam logic [2:0] A_CLR    = 3'd5;
    localparam logic [2:0] A_CNT    = 3'd6;

endpackage

// File: rtl/lpcnt_edge_det.sv
// Edge detector for one counting input.
// Registers the previous level and flags rising and falling edges.
// Reports whether the edge matches the selected polarity.
// Assumes the input is already synchronous to clk.
module lpcnt_edge_det
    import lpcnt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sig,
    input  edge_sel_e sel,
    output logic      rise,
    output logic      fall,
    output logic      act
);
    logic prev_q;

    // Hold last cycle's level of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    assign rise = sig & ~prev_q;
    assign fall = ~sig & prev_q;

    // Pick the edges that the polarity setting counts.
    always_comb begin
        case (sel)
            EDGE_RISE: act = rise;
            EDGE_FALL: act = fall;
            EDGE_BOTH: act = rise | fall;
            default:   act = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpcnt_front.sv
// Counting front end.
// Turns the two inputs into a one-cycle step strobe and a direction.
// Simple mode counts selected edges of input A upward.
// Quadrature mode decodes the direction from the level of the other input.
// Assumes synchronous inputs.
module lpcnt_front
    import lpcnt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_a,
    input  logic      in_b,
    input  logic      quad,
    input  edge_sel_e sel,
    output logic      step,
    output logic      up
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] sig, rise, fall, act;
    assign sig = {in_b, in_a};

    for (genvar g = 0; g < N_IN; g++) begin : g_det
        lpcnt_edge_det u_det (
            .clk  (clk),
            .rst_n(rst_n),
            .sig  (sig[g]),
            .sel  (sel),
            .rise (rise[g]),
            .fall (fall[g]),
            .act  (act[g])
        );
    end

    logic any_a, any_b;
    assign any_a = rise[0] | fall[0];
    assign any_b = rise[1] | fall[1];

    // Decode step and direction for the current mode.
    always_comb begin
        step = 1'b0;
        up   = 1'b1;
        if (!quad) begin
            step = act[0];
        end else if (act[0] && !any_b) begin
            step = 1'b1;
            up   = rise[0] ? ~sig[1] : sig[1];
        end else if (act[1] && !any_a) begin
            step = 1'b1;
            up   = rise[1] ? sig[0] : ~sig[0];
        end
    end

    // R12: both inputs changing together never produces a step in quadrature mode
    assert_no_dual_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (quad && any_a && any_b) |-> !step);

    // R7: simple mode only counts upward and only on input A activity
    assert_simple_up_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!quad && step) |-> (up && any_a));
endmodule

// File: rtl/lpcnt_defer_ld.sv
// Deferred load channel for one register (reload or compare).
// An accepted write is parked, then copied into the visible value DELAY cycles later.
// A one-cycle done pulse marks the copy.
// A newer write restarts the wait, and cancel drops a pending load.
// Assumes DELAY >= 1.
module lpcnt_defer_ld #(
    parameter int             W         = 16,
    parameter int             DELAY     = 3,
    parameter logic [W-1:0]   RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         cancel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic         done
);
    localparam int TW = $clog2(DELAY + 1);

    logic [TW-1:0] tmr_q;
    logic [W-1:0]  pend_q;

    assign done = (tmr_q == TW'(1)) && !wr && !cancel;

    // Park writes, count down, then publish the parked value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q  <= '0;
            pend_q <= '0;
            value  <= RESET_VAL;
        end else if (wr) begin
            pend_q <= wdata;
            tmr_q  <= TW'(DELAY);
        end else if (cancel) begin
            tmr_q  <= '0;
        end else if (tmr_q == TW'(1)) begin
            value  <= pend_q;
            tmr_q  <= '0;
        end else if (tmr_q != '0) begin
            tmr_q  <= tmr_q - TW'(1);
        end
    end

    // R3: the visible value moves only at the end of a pending load
    assert_value_only_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q != TW'(1)) |=> $stable(value));

    // R3: a load that reaches the end of its wait publishes the parked data
    assert_load_publishes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (value == $past(pend_q)));
endmodule

// File: rtl/lpcnt_core.sv
// Counter core.
// Steps up or down while running and wraps at 0 and at the reload value.
// Clears on request and flags when a step lands on the compare value.
// Assumes step and up come from the front end in the same cycle.
module lpcnt_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    input  logic         step,
    input  logic         up,
    input  logic [W-1:0] reload,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         match
);
    logic         adv;
    logic [W-1:0] nxt;

    assign adv = run & step;

    // Next count with wrap at both ends.
    always_comb begin
        if (up) nxt = (cnt >= reload) ? '0 : cnt + W'(1);
        else    nxt = (cnt == '0) ? reload : cnt - W'(1);
    end

    assign match = adv && (nxt == cmp);

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (adv) cnt <= nxt;
    end

    // R5: no movement unless running
    assert_hold_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt));

    // R9: upward wrap at the ceiling
    assert_wrap_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && up && !clr && cnt == reload) |=> (cnt == '0));

    // R9: downward wrap at zero
    assert_wrap_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !up && !clr && cnt == '0) |=> (cnt == $past(reload)));

    // R10: a clear empties the count
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/lpcnt_regs.sv
// Register file.
// Holds config, enable/start, the deferred reload and compare channels and the sticky flags.
// Also provides the read mux.
// Config writes are locked while enabled, and load writes are accepted only while enabled.
// Assumes at most one bus write per cycle.
module lpcnt_regs
    import lpcnt_pkg::*;
#(
    parameter int W          = 16,
    parameter int LOAD_DELAY = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cnt,
    input  logic         match,
    output cfg_t         cfg,
    output logic         run,
    output logic         cnt_clr,
    output logic [W-1:0] reload,
    output logic [W-1:0] cmp,
    output logic [W-1:0] rdata
);
    localparam int N_LD  = 2;
    localparam int N_FLG = 3;

    logic             en_q, start_q;
    logic [N_FLG-1:0] flg_q;
    logic             ctrl_wr, off_wr, cfg_wr, clr_wr;
    logic [N_FLG-1:0] clr_bits;
    logic [W-1:0]     ld_val [N_LD];
    logic [N_LD-1:0]  ld_done;

    assign ctrl_wr  = we && (addr == A_CTRL);
    assign off_wr   = ctrl_wr && !wdata[0];
    assign cfg_wr   = we && (addr == A_CFG) && !en_q && (wdata[2:1] != 2'b11);
    assign clr_wr   = we && (addr == A_CLR);
    assign clr_bits = clr_wr ? wdata[N_FLG-1:0] : '0;
    assign cnt_clr  = off_wr;
    assign run      = en_q & start_q;

    // Enable and start bits; start needs enable already on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            start_q <= 1'b0;
        end else if (ctrl_wr) begin
            if (!wdata[0]) begin
                en_q    <= 1'b0;
                start_q <= 1'b0;
            end else begin
                en_q    <= 1'b1;
                start_q <= start_q | (wdata[1] & en_q);
            end
        end
    end

    // Config register, writable only while disabled and with a legal edge code.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= '0;
        else if (cfg_wr) cfg <= cfg_t'(wdata[CFG_W-1:0]);
    end

    for (genvar g = 0; g < N_LD; g++) begin : g_ld
        localparam logic [2:0]   LD_ADDR = (g == 0) ? A_RELOAD : A_CMP;
        localparam logic [W-1:0] LD_RST  = (g == 0) ? {W{1'b1}} : {W{1'b0}};
        lpcnt_defer_ld #(
            .W        (W),
            .DELAY    (LOAD_DELAY),
            .RESET_VAL(LD_RST)
        ) u_ld (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (we && en_q && (addr == LD_ADDR)),
            .cancel(off_wr),
            .wdata (wdata),
            .value (ld_val[g]),
            .done  (ld_done[g])
        );
    end

    assign reload = ld_val[0];
    assign cmp    = ld_val[1];

    // Sticky flags: write-one-to-clear, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= (flg_q & ~clr_bits) | {match, ld_done};
    end

    // Read mux.
    always_comb begin
        case (addr)
            A_CFG:    rdata = {{(W-CFG_W){1'b0}}, cfg};
            A_CTRL:   rdata = {{(W-2){1'b0}}, start_q, en_q};
            A_RELOAD: rdata = reload;
            A_CMP:    rdata = cmp;
            A_STAT:   rdata = {{(W-N_FLG){1'b0}}, flg_q};
            A_CNT:    rdata = cnt;
            default:  rdata = '0;
        endcase
    end

    // R6: config frozen while enabled
    assert_cfg_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(cfg));

    // R2: load registers cannot change while disabled
    assert_loads_frozen_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> ($stable(reload) && $stable(cmp)));

    // R4: reload flag stays until explicitly cleared
    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_q[0] && !clr_bits[0]) |=> flg_q[0]);

    // R5: start can only rise after enable was already on
    assert_start_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_q) |-> $past(en_q));

    // R10: disable write leaves enable and start low
    assert_off_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        off_wr |=> (!en_q && !start_q));
endmodule

// File: rtl/lpcnt_top.sv
// Low-power event counter top.
// Joins the register file, the counting front end and the counter core.
// Assumes in_a/in_b are synchronous to clk and bus writes last one cycle.
module lpcnt_top
    import lpcnt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int LOAD_DELAY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             in_a,
    input  logic             in_b
);
    cfg_t             cfg;
    logic             run, cnt_clr, step, up, match;
    logic [CNT_W-1:0] reload, cmp, cnt;

    lpcnt_regs #(.W(CNT_W), .LOAD_DELAY(LOAD_DELAY)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .cnt    (cnt),
        .match  (match),
        .cfg    (cfg),
        .run    (run),
        .cnt_clr(cnt_clr),
        .reload (reload),
        .cmp    (cmp),
        .rdata  (bus_rdata)
    );

    lpcnt_front u_front (
        .clk  (clk),
        .rst_n(rst_n),
        .in_a (in_a),
        .in_b (in_b),
        .quad (cfg.quad),
        .sel  (cfg.edge_sel),
        .step (step),
        .up   (up)
    );

    lpcnt_core #(.W(CNT_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (cnt_clr),
        .step  (step),
        .up    (up),
        .reload(reload),
        .cmp   (cmp),
        .cnt   (cnt),
        .match (match)
    );
endmodule

// File: tb/tb_lpcnt_top.sv
`timescale 1ns/1ps
module tb_lpcnt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        in_a = 1'b0, in_b = 1'b0;

    always #2.5 clk = ~clk;

    lpcnt_top dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_a(in_a), .in_b(in_b)
    );

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit checking = 0;

    // reference model state
    int m_quad, m_pol, m_presc, m_en, m_start, m_arr, m_cmp, m_cnt, m_flg;
    int m_pend[2], m_tmr[2];
    int pa, pb;

    function automatic int m_read(int ad);
        case (ad)
            0: return m_quad | (m_pol << 1) | (m_presc << 3);
            1: return m_en | (m_start << 1);
            2: return m_arr;
            3: return m_cmp;
            4: return m_flg;
            6: return m_cnt;
            default: return 0;
        endcase
    endfunction

    function automatic int sel_act(int r, int f);
        if (m_pol == 0) return r;
        if (m_pol == 1) return f;
        if (m_pol == 2) return r | f;
        return 0;
    endfunction

    // behavioural model, one update per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_quad = 0; m_pol = 0; m_presc = 0; m_en = 0; m_start = 0;
            m_arr = 16'hFFFF; m_cmp = 0; m_cnt = 0; m_flg = 0;
            m_pend[0] = 0; m_pend[1] = 0; m_tmr[0] = 0; m_tmr[1] = 0;
            pa = 0; pb = 0;
        end else begin
            int a, b, ar, af, br, bf, step, up, nc, setm, done[2], en_old, d, ad;
            a = in_a; b = in_b; d = bus_wdata; ad = bus_addr;
            ar = a & ~pa; af = ~a & pa; br = b & ~pb; bf = ~b & pb;
            step = 0; up = 1;
            if (m_quad == 0) step = sel_act(ar, af);
            else if (sel_act(ar, af) && !(br || bf)) begin step = 1; up = ar ? !b : b; end
            else if (sel_act(br, bf) && !(ar || af)) begin step = 1; up = br ? a : !a; end
            nc = m_cnt; setm = 0;
            if (m_en && m_start && step) begin
                if (up) nc = (m_cnt >= m_arr) ? 0 : m_cnt + 1;
                else    nc = (m_cnt == 0) ? m_arr : m_cnt - 1;
                if (nc == m_cmp) setm = 1;
            end
            en_old = m_en;
            for (int i = 0; i < 2; i++) begin
                done[i] = 0;
                if (bus_we && ad == 2 + i && en_old) begin m_pend[i] = d; m_tmr[i] = 3; end
                else if (bus_we && ad == 1 && (d & 1) == 0) m_tmr[i] = 0;
                else if (m_tmr[i] == 1) begin
                    if (i == 0) m_arr = m_pend[i]; else m_cmp = m_pend[i];
                    done[i] = 1; m_tmr[i] = 0;
                end else if (m_tmr[i] > 0) m_tmr[i]--;
            end
            if (bus_we && ad == 1) begin
                if ((d & 1) == 0) begin m_en = 0; m_start = 0; nc = 0; end
                else begin m_start = m_start | (((d >> 1) & 1) & en_old); m_en = 1; end
            end
            if (bus_we && ad == 0 && !en_old && ((d >> 1) & 3) != 3) begin
                m_quad = d & 1; m_pol = (d >> 1) & 3; m_presc = (d >> 3) & 7;
            end
            if (bus_we && ad == 5) m_flg = m_flg & ~(d & 7);
            m_flg = m_flg | done[0] | (done[1] << 1) | (setm << 2);
            m_cnt = nc;
            pa = a; pb = b;
        end
    end

    task automatic cyc(input bit we, input int ad, input int d, input bit a, input bit b);
        @(negedge clk);
        if (checking) begin
            int exp;
            exp = m_read(bus_addr);
            checks++;
            if (bus_rdata !== exp[15:0]) begin
                errors++;
                $display("FAIL %s: addr %0d actual %h expected %h", cur_req, bus_addr, bus_rdata, exp[15:0]);
            end
        end
        bus_we = we; bus_addr = ad[2:0]; bus_wdata = d[15:0]; in_a = a; in_b = b;
    endtask

    task automatic wr(input int ad, input int d); cyc(1, ad, d, in_a, in_b); endtask
    task automatic rd(input int ad, input int n);
        for (int i = 0; i < n; i++) cyc(0, ad, 0, in_a, in_b);
    endtask
    task automatic tog_a(input int n, input bit with_b);
        for (int i = 0; i < n; i++) begin
            cyc(0, 6, 0, ~in_a, with_b ? ~in_b : in_b);
            cyc(0, 6, 0, in_a, in_b);
        end
    endtask

    int ph = 0;
    task automatic qstep(input int n, input bit fwd);
        bit qa[4] = '{0, 1, 1, 0};
        bit qb[4] = '{0, 0, 1, 1};
        for (int i = 0; i < n; i++) begin
            ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
            cyc(0, 6, 0, qa[ph], qb[ph]);
            cyc(0, 4, 0, in_a, in_b);
        end
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual running expected done");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        checking = 1;
        cur_req = "R1"; for (int k = 0; k < 8; k++) rd(k, 1);
        cur_req = "R2"; wr(2, 16'h0010); rd(2, 5); wr(3, 5); rd(3, 5); rd(4, 1);
        cur_req = "R6"; wr(0, 16'h0006); rd(0, 2); wr(0, 16'h002A); rd(0, 2); wr(0, 0); rd(0, 1);
        cur_req = "R5"; wr(1, 3); rd(1, 2); tog_a(3, 0); rd(1, 1);
        cur_req = "R3"; wr(2, 9); rd(2, 5); rd(4, 2); wr(3, 4); rd(3, 5); rd(4, 1);
        cur_req = "R4"; rd(4, 3); wr(5, 1); rd(4, 3); wr(5, 2); rd(4, 2);
        cur_req = "R6"; wr(0, 16'h0002); rd(0, 3);
        cur_req = "R5"; wr(1, 3); rd(1, 2);
        cur_req = "R7"; tog_a(4, 1);
        cur_req = "R7"; for (int i = 0; i < 6; i++) begin cyc(0, 6, 0, in_a, ~in_b); end
        cur_req = "R9"; tog_a(8, 0);
        cur_req = "R11"; rd(4, 2); wr(5, 4); rd(4, 2);
        cur_req = "R10"; wr(1, 0); rd(6, 1); rd(1, 2);
        cur_req = "R7"; wr(0, 2); wr(1, 1); wr(1, 3); tog_a(5, 0);
        wr(1, 0); wr(0, 4); wr(1, 1); wr(1, 3); tog_a(5, 0);
        cur_req = "R10"; wr(2, 3); wr(1, 0); rd(2, 6); rd(4, 1);
        cur_req = "R8"; in_a = 0; in_b = 0; ph = 0; rd(6, 2);
        wr(0, 5); wr(1, 1); wr(1, 3); rd(6, 1);
        qstep(6, 1); rd(6, 1);
        qstep(9, 0); rd(6, 1);
        cur_req = "R9"; qstep(4, 0); rd(6, 1);
        cur_req = "R12"; cyc(0, 6, 0, ~in_a, ~in_b); rd(6, 3);
        cur_req = "R8"; wr(1, 0); in_a = 0; in_b = 0; ph = 0; rd(6, 2);
        wr(0, 1); wr(1, 1); wr(1, 3); qstep(8, 1); rd(6, 1); qstep(5, 0); rd(6, 1);
        wr(1, 0); wr(0, 3); wr(1, 1); wr(1, 3); qstep(8, 1); rd(6, 1);
        cur_req = "R4"; wr(5, 7); rd(4, 2);
        summary();
    end
endmodule